// File: doc/BRIEF.md
# Dual-Memory RAM Self-Test Controller

This block runs a built-in self-test on two single-port RAMs that sit beside it: a coefficient memory and a data memory. While the test runs it drives the address, write data and write enable of both memories. It applies a March C- algorithm to both memories at once and compares every read against the value it expects. Each memory has its own sticky failure flag.

A test starts only when the channel is asleep and the test enable is set. Software then polls a three-bit status word. Bit 0 is a busy flag. Bit 1 flags a coefficient-memory failure and bit 2 flags a data-memory failure. If the enable is cleared or the channel wakes up during a run, the run is abandoned and the controller returns to idle.

Top module: `ramBist`

## Requirements
- R1: A run begins on the clock edge at which `sleepMode && bistEnable` is high after having been low in the previous cycle. From then on, status bit 0 reads 1. Neither input alone starts a run.
- R2: After reset and while idle, the status word is 3'b000 and both memory write enables stay low.
- R3: Status bit 0 is 1 while the test is incomplete and 0 once it has finished.
- R4: After completion, bit 1 = 1 means the coefficient memory failed and bit 2 = 1 means the data memory failed. The two flags are independent and both may be set. 3'b000 means both memories passed.
- R5: A complete run keeps status bit 0 high for exactly 10*DEPTH+1 cycles (641 at the default depth of 64), which is within 1600 cycles.
- R6: March order for each memory. The first DEPTH writes go to addresses 0 through DEPTH-1 in ascending order with all-zero data. Each run performs 5*DEPTH writes, and every written word is all zeros or all ones. The last write goes to address 0.
- R7: A fail flag stays set once set until the next run starts. The start of a run clears both flags.
- R8: If either input drops while status bit 0 is high, the run is abandoned. One cycle later the status word is 3'b000.
- R9: After completion, the result stays unchanged while the inputs stay high and after they drop. Starting a new run needs a fresh rising edge of `sleepMode && bistEnable`.
- R10: A single bit stuck at 0 or at 1 at any address of either memory sets that memory's fail flag and no other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepMode | input | 1 | Channel is in sleep mode |
| bistEnable | input | 1 | Test enable bit |
| status | output | 3 | {dataFail, coefFail, busy} |
| coefAddr | output | ADDR_W | Coefficient memory address |
| coefWdata | output | DATA_W | Coefficient memory write data |
| coefWe | output | 1 | Coefficient memory write enable |
| coefRdata | input | DATA_W | Coefficient memory read data, one cycle after the address |
| dataAddr | output | ADDR_W | Data memory address |
| dataWdata | output | DATA_W | Data memory write data |
| dataWe | output | 1 | Data memory write enable |
| dataRdata | input | DATA_W | Data memory read data, one cycle after the address |

## Verification
The bench builds the block with its defaults: ADDR_W = 6 (64 words), DATA_W = 16 and a 1600-cycle bound. At this size a full run takes 641 cycles, so the bench can compare the exact busy length against the bound and trace every write address in both sweep directions. It can also inject stuck-at faults at any address and bit of either memory, including the edge addresses where the sweep turns around. Random fault sets are mixed with directed abort, gating and result-hold cases.

// File: rtl/ramBistPkg.sv
package ramBistPkg;
  typedef struct packed {
    logic active;
    logic wr;
    logic rd;
    logic wrBit;
    logic expBit;
    logic clearFlags;
  } bistStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_DONE} bistState_t;

  localparam int NUM_ELEM = 6;
endpackage

// File: rtl/ramBistCtrl.sv
module ramBistCtrl
  import ramBistPkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int MAX_CYCLES = 1600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              armed,
  output bistStrobe_t       strb,
  output logic [ADDR_W-1:0] addr,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [2:0] LAST_ELEM = 3'(NUM_ELEM - 1);
  localparam int CNT_W = $clog2(MAX_CYCLES + 2);

  bistState_t state;
  logic       armedPrev;
  logic [2:0] elem;
  logic       step;

  // March C- elements: 0 up(w0) 1 up(r0,w1) 2 up(r1,w0) 3 dn(r0,w1) 4 dn(r1,w0) 5 dn(r0)
  function automatic logic elemDown(input logic [2:0] e);
    return e >= 3'd3;
  endfunction
  function automatic logic elemRead(input logic [2:0] e);
    return e != 3'd0;
  endfunction
  function automatic logic elemWrite(input logic [2:0] e);
    return e != LAST_ELEM;
  endfunction

  logic startReq, abort, opIsRead, opIsWrite, lastOp, lastAddr;

  always_comb begin
    startReq  = armed && !armedPrev && (state == ST_IDLE || state == ST_DONE);
    abort     = !armed && (state == ST_RUN || state == ST_DRAIN);
    opIsRead  = elemRead(elem) && !step;
    opIsWrite = elemWrite(elem) && (step || !elemRead(elem));
    lastOp    = step || !(elemRead(elem) && elemWrite(elem));
    lastAddr  = elemDown(elem) ? (addr == '0) : (addr == TOP_ADDR);
    strb.active     = (state == ST_RUN) || (state == ST_DRAIN);
    strb.wr         = (state == ST_RUN) && opIsWrite;
    strb.rd         = (state == ST_RUN) && opIsRead;
    strb.wrBit      = (elem == 3'd1) || (elem == 3'd3);
    strb.expBit     = (elem == 3'd2) || (elem == 3'd4);
    strb.clearFlags = startReq || abort;
    busy            = strb.active;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      armedPrev <= 1'b0;
      elem      <= '0;
      addr      <= '0;
      step      <= 1'b0;
    end else begin
      armedPrev <= armed;
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (startReq) begin
            state <= ST_RUN;
            elem  <= '0;
            addr  <= '0;
            step  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (abort) begin
            state <= ST_IDLE;
          end else if (lastOp) begin
            step <= 1'b0;
            if (lastAddr) begin
              if (elem == LAST_ELEM) begin
                state <= ST_DRAIN;
              end else begin
                elem <= elem + 3'd1;
                addr <= elemDown(elem + 3'd1) ? TOP_ADDR : '0;
              end
            end else begin
              addr <= elemDown(elem) ? addr - 1'b1 : addr + 1'b1;
            end
          end else begin
            step <= 1'b1;
          end
        end
        ST_DRAIN: state <= abort ? ST_IDLE : ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // Busy-length checker counter
  logic [CNT_W-1:0] busyCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  assert_bounded_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= CNT_W'(MAX_CYCLES));

  assert_start_gated_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(armed));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !armed) |=> !busy);
endmodule

// File: rtl/ramBistDatapath.sv
module ramBistDatapath
  import ramBistPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  bistStrobe_t            strb,
  input  logic [ADDR_W-1:0]      addrIn,
  output logic [1:0][ADDR_W-1:0] memAddr,
  output logic [1:0][DATA_W-1:0] memWdata,
  output logic [1:0]             memWe,
  input  logic [1:0][DATA_W-1:0] memRdata,
  output logic [1:0]             failFlag
);
  logic cmpValid, cmpExp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpValid <= 1'b0;
      cmpExp   <= 1'b0;
    end else begin
      cmpValid <= strb.rd && !strb.clearFlags;
      cmpExp   <= strb.expBit;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_mem
    always_comb begin
      memAddr[i]  = strb.active ? addrIn : '0;
      memWdata[i] = strb.wr ? {DATA_W{strb.wrBit}} : '0;
      memWe[i]    = strb.wr;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 failFlag[i] <= 1'b0;
      else if (strb.clearFlags)  failFlag[i] <= 1'b0;
      else if (cmpValid && (memRdata[i] != {DATA_W{cmpExp}}))
                                 failFlag[i] <= 1'b1;
    end

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
      (failFlag[i] && !strb.clearFlags) |=> failFlag[i]);

    assert_clear_on_start_R7: assert property (@(posedge clk) disable iff (!rstN)
      strb.clearFlags |=> !failFlag[i]);

    assert_no_write_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
      !strb.active |-> !memWe[i]);
  end
endmodule

// File: rtl/ramBist.sv
module ramBist
  import ramBistPkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int MAX_CYCLES = 1600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sleepMode,
  input  logic              bistEnable,
  output logic [2:0]        status,
  output logic [ADDR_W-1:0] coefAddr,
  output logic [DATA_W-1:0] coefWdata,
  output logic              coefWe,
  input  logic [DATA_W-1:0] coefRdata,
  output logic [ADDR_W-1:0] dataAddr,
  output logic [DATA_W-1:0] dataWdata,
  output logic              dataWe,
  input  logic [DATA_W-1:0] dataRdata
);
  bistStrobe_t             strb;
  logic [ADDR_W-1:0]       addr;
  logic                    busy;
  logic [1:0][ADDR_W-1:0]  memAddr;
  logic [1:0][DATA_W-1:0]  memWdata;
  logic [1:0]              memWe;
  logic [1:0][DATA_W-1:0]  memRdata;
  logic [1:0]              failFlag;

  ramBistCtrl #(.ADDR_W(ADDR_W), .MAX_CYCLES(MAX_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .armed(sleepMode && bistEnable),
    .strb(strb), .addr(addr), .busy(busy)
  );

  assign memRdata = {dataRdata, coefRdata};

  ramBistDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrIn(addr),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata), .failFlag(failFlag)
  );

  assign coefAddr  = memAddr[0];
  assign coefWdata = memWdata[0];
  assign coefWe    = memWe[0];
  assign dataAddr  = memAddr[1];
  assign dataWdata = memWdata[1];
  assign dataWe    = memWe[1];
  assign status    = {failFlag[1], failFlag[0], busy};
endmodule

// File: tb/ramBist_tb.sv
module ramBist_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;
  localparam int RUN_LEN = 10 * DEPTH + 1;

  logic clk = 0, rstN = 0, sleepMode = 0, bistEnable = 0;
  logic [2:0] status;
  logic [AW-1:0] coefAddr, dataAddr;
  logic [DW-1:0] coefWdata, dataWdata, coefRdata, dataRdata;
  logic coefWe, dataWe;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ramBist u_dut (
    .clk(clk), .rstN(rstN), .sleepMode(sleepMode), .bistEnable(bistEnable),
    .status(status), .coefAddr(coefAddr), .coefWdata(coefWdata), .coefWe(coefWe),
    .coefRdata(coefRdata), .dataAddr(dataAddr), .dataWdata(dataWdata),
    .dataWe(dataWe), .dataRdata(dataRdata)
  );

  // Memory models with stuck-at fault injection: index 0 coef, 1 data
  logic [DW-1:0] memC [DEPTH];
  logic [DW-1:0] memD [DEPTH];
  bit            fOn [2];
  int            fAddr [2];
  int            fBit [2];
  bit            fVal [2];

  function automatic logic [DW-1:0] faulty(input int m, input int a, input logic [DW-1:0] v);
    logic [DW-1:0] r = v;
    if (fOn[m] && a == fAddr[m]) r[fBit[m]] = fVal[m];
    return r;
  endfunction

  always @(posedge clk) begin
    coefRdata <= faulty(0, int'(coefAddr), memC[coefAddr]);
    dataRdata <= faulty(1, int'(dataAddr), memD[dataAddr]);
    if (coefWe) memC[coefAddr] <= coefWdata;
    if (dataWe) memD[dataAddr] <= dataWdata;
  end

  // Write monitor (sampled mid-cycle)
  int  wrCntC, wrCntD, lastWrAddr;
  bit  orderOk, patOk;
  always @(negedge clk) begin
    if (coefWe) begin
      if (wrCntC < DEPTH && (int'(coefAddr) != wrCntC || coefWdata != '0)) orderOk = 0;
      if (coefWdata != '0 && coefWdata != '1) patOk = 0;
      lastWrAddr = int'(coefAddr);
      wrCntC++;
    end
    if (dataWe) begin
      if (dataAddr != coefAddr || dataWdata != coefWdata) orderOk = 0;
      wrCntD++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expStatus(input bit cf, input bit df);
    return {df, cf, 1'b0};
  endfunction

  task automatic clearMon();
    wrCntC = 0; wrCntD = 0; lastWrAddr = -1; orderOk = 1; patOk = 1;
  endtask

  task automatic setFault(input int m, input bit on, input int a, input int b, input bit v);
    fOn[m] = on; fAddr[m] = a; fBit[m] = b; fVal[m] = v;
  endtask

  task automatic disarm();
    @(negedge clk); sleepMode = 0; bistEnable = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic fullRun(input string tag);
    int cnt = 0;
    clearMon();
    @(negedge clk); sleepMode = 1; bistEnable = 1;
    @(negedge clk);
    check({tag, " R1 busy after arm"}, status[0], 1'b1);
    while (status[0] && cnt < 2000) begin cnt++; @(negedge clk); end
    check({tag, " R5 busy length"}, cnt, RUN_LEN);
    check({tag, " R3/R4/R10 status"}, status, expStatus(fOn[0], fOn[1]));
    check({tag, " R6 write count"}, wrCntC, 5 * DEPTH);
    check({tag, " R6 order/pattern"}, {orderOk, patOk, wrCntD == 5 * DEPTH}, 3'b111);
    check({tag, " R6 last write addr"}, lastWrAddr, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    setFault(0, 0, 0, 0, 0);
    setFault(1, 0, 0, 0, 0);
    clearMon();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R2 reset status", status, 3'b000);
    check("R2 reset write enables", {coefWe, dataWe}, 2'b00);

    // R1: neither input alone starts
    bistEnable = 1;
    repeat (20) @(negedge clk);
    check("R1 enable only", {status, wrCntC[7:0]}, 11'd0);
    bistEnable = 0; sleepMode = 1;
    repeat (20) @(negedge clk);
    check("R1 sleep only", {status, wrCntC[7:0]}, 11'd0);
    sleepMode = 0;

    fullRun("clean");
    disarm();

    // Directed faults at sweep turn-around addresses
    setFault(0, 1, DEPTH - 1, DW - 1, 0);
    fullRun("coef sa0 top");
    // R9: hold while armed, and no restart without a new rise
    repeat (50) @(negedge clk);
    check("R9 held while armed", status, 3'b010);
    @(negedge clk); bistEnable = 0;
    repeat (3) @(negedge clk);
    check("R9 held after drop", status, 3'b010);
    setFault(0, 0, 0, 0, 0);
    @(negedge clk); bistEnable = 1;
    @(negedge clk);
    check("R7 flags cleared at new start", status, 3'b001);
    // R8: abort via enable drop
    repeat (100) @(negedge clk);
    bistEnable = 0;
    @(negedge clk);
    check("R8 abort by enable", status, 3'b000);
    disarm();

    setFault(1, 1, 0, 0, 1);
    fullRun("data sa1 bottom");
    disarm();
    setFault(0, 1, 17, 5, 1);
    setFault(1, 1, DEPTH - 1, 9, 0);
    fullRun("both");
    disarm();

    // R8: abort via sleep drop after a fault was flagged
    setFault(0, 1, 0, 3, 1);
    setFault(1, 0, 0, 0, 0);
    @(negedge clk); sleepMode = 1; bistEnable = 1;
    repeat (200) @(negedge clk);
    check("R7 flag set mid-run", status, 3'b011);
    sleepMode = 0;
    @(negedge clk);
    check("R8 abort by sleep", status, 3'b000);
    repeat (5) @(negedge clk);
    check("R8 stays idle", {status, coefWe}, 4'b0000);
    disarm();

    // Random fault sets
    for (int t = 0; t < 8; t++) begin
      for (int m = 0; m < 2; m++)
        setFault(m, bit'($urandom % 2), int'($urandom % DEPTH), int'($urandom % DW), bit'($urandom % 2));
      fullRun($sformatf("rand%0d", t));
      disarm();
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule